// File: doc/BRIEF.md
# Drive Seek and Status Generator

This block carries out the positioning and housekeeping commands of a floppy disk controller for up to four drives. A command (opcode, drive number, head bit and target cylinder) is presented for one clock with a valid strobe. The block evaluates it against the selected drive's ready, write-protect and two-sided flags and its cylinder count. It then updates that drive's present-cylinder register and returns the encoded completion bytes one cycle later.

Each drive keeps its own present-cylinder register and track-0 flag. Seek moves a drive to a cylinder after a bounds check. Recalibrate returns it to cylinder 0. Sense-drive reports the drive flags, and read-ID reports the drive's position. Specify and a format request only produce completion status, and any other opcode is flagged as invalid. Step-pulse timing and sector data movement are handled elsewhere.

Top module: `drv_cmd_status`

## Requirements
- R1: After reset `done` is 0, all status outputs are 0, and every drive sits at cylinder 0 with track 0 set. `done` is high for exactly the one cycle after each cycle in which `cmd_valid` is high, and all result outputs are valid during that cycle.
- R2: The completion byte `st0` has this layout: bits 7..6 are the completion code (00 normal, 01 abnormal, 10 invalid command, 11 ready changed), bit 5 is seek end, bit 4 is equipment check (always 0), bit 3 is not ready, bit 2 is the head, and bits 1..0 are the drive. The head and drive fields echo the selection on every command. `st1` and `st2` are always 0.
- R3: Seek (opcode 0x0F), recalibrate (0x07) or format (0x0D) on a drive that is not ready gives code 01 with not-ready set and seek end clear. The drive's cylinder does not change.
- R4: Recalibrate on a ready drive sets its cylinder to 0 and its track-0 flag, and gives code 00 with seek end set.
- R5: A seek on a ready drive to a target below that drive's cylinder count loads the target and gives code 00 with seek end set. The track-0 flag is set exactly when the new cylinder is 0.
- R6: A seek on a ready drive to a target equal to or above its cylinder count gives code 01 with seek end set and not-ready clear. The drive's cylinder does not change.
- R7: `st3` reports the selected drive after every command: bit 7 fault (0), bit 6 write protect, bit 5 ready, bit 4 track 0 (after the command), bit 3 two-sided, bit 2 head, bits 1..0 drive. Sense-drive (0x04) gives code 00 in `st0`.
- R8: Read-ID (0x0A) on a ready drive gives code 00, `res_cyl` equal to that drive's cylinder, `res_sector` = 1 and `res_size` = `cur_size`. On a drive that is not ready it gives code 11 with not-ready set. For every command other than a successful read-ID, `res_sector` and `res_size` are 0.
- R9: Format on a ready, write-protected drive gives code 01 with not-ready clear. Format on a ready, writable drive and specify (0x03) give code 00 with seek end clear.
- R10: Any other opcode gives code 10 and leaves every cylinder unchanged.
- R11: `res_cyl` is the selected drive's cylinder after the command. A command on one drive never changes another drive's cylinder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 5 | Command opcode |
| cmd_unit | input | 2 | Selected drive |
| cmd_head | input | 1 | Selected head |
| cmd_cyl | input | CYL_W | Seek target cylinder |
| cur_size | input | SIZE_W | Sector size code returned by read-ID |
| drv_ready | input | NUM_DRV | Per-drive ready flag |
| drv_wprot | input | NUM_DRV | Per-drive write-protect flag |
| drv_twoside | input | NUM_DRV | Per-drive two-sided flag |
| drv_maxcyl | input | NUM_DRV*CYL_W | Per-drive cylinder count, drive 0 in the low bits |
| done | output | 1 | Result valid pulse |
| st0 | output | 8 | Completion byte |
| st1 | output | 8 | Transfer status byte, always 0 here |
| st2 | output | 8 | Transfer status byte, always 0 here |
| st3 | output | 8 | Drive status byte |
| res_cyl | output | CYL_W | Selected drive's cylinder after the command |
| res_sector | output | 8 | Sector number from read-ID |
| res_size | output | SIZE_W | Size code from read-ID |

## Verification
The bench probes the edges of the seek bound. A target one below the cylinder count must move the drive, and a target equal to the count must not; an off-by-one compare would either refuse the last legal cylinder or move the head past the end. It issues seeks to cylinder 0 and away from it and checks the track-0 flag both ways, since a flag that only sets would leave a stale track-0 report. It puts a not-ready drive through seek, recalibrate, read-ID and format: a design that mixed up the codes would report ready-changed for a seek or abnormal for read-ID. It also interleaves commands across drives, which shows up any write that lands on the wrong drive's cylinder register.

// File: rtl/drv_cmd_pkg.sv
package drv_cmd_pkg;
   localparam int MAX_DRV = 4;

   localparam logic [4:0] OP_SPECIFY = 5'h03;
   localparam logic [4:0] OP_SENSE   = 5'h04;
   localparam logic [4:0] OP_RECAL   = 5'h07;
   localparam logic [4:0] OP_READID  = 5'h0A;
   localparam logic [4:0] OP_FORMAT  = 5'h0D;
   localparam logic [4:0] OP_SEEK    = 5'h0F;

   typedef enum logic [1:0] {
      CC_NORMAL  = 2'b00,
      CC_ABORT   = 2'b01,
      CC_BADCMD  = 2'b10,
      CC_RDYCHG  = 2'b11
   } cc_e;

   function automatic logic [7:0] pack_st0(input cc_e cc, input logic se,
                                           input logic nr, input logic hd,
                                           input logic [1:0] un);
      return {cc, se, 1'b0, nr, hd, un};
   endfunction

   function automatic logic op_known(input logic [4:0] op);
      return (op == OP_SPECIFY) || (op == OP_SENSE) || (op == OP_RECAL) ||
             (op == OP_READID) || (op == OP_FORMAT) || (op == OP_SEEK);
   endfunction
endpackage

// File: rtl/drv_cyl_bank.sv
module drv_cyl_bank
   import drv_cmd_pkg::*;
#(
   parameter int NUM_DRV = 4,
   parameter int CYL_W   = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       sel,
   input  logic [CYL_W-1:0] wr_cyl,
   output logic [CYL_W-1:0] rd_cyl,
   output logic             rd_t0
);
   logic [CYL_W-1:0] cyl_a [MAX_DRV];
   logic             t0_a  [MAX_DRV];

   for (genvar g = 0; g < MAX_DRV; g++) begin : g_drv
      if (g < NUM_DRV) begin : g_real
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cyl_a[g] <= '0;
               t0_a[g]  <= 1'b1;
            end else if (wr_en && sel == g[1:0]) begin
               cyl_a[g] <= wr_cyl;
               t0_a[g]  <= (wr_cyl == '0);
            end
         end
      end else begin : g_absent
         assign cyl_a[g] = '0;
         assign t0_a[g]  = 1'b1;
      end
   end

   assign rd_cyl = cyl_a[sel];
   assign rd_t0  = t0_a[sel];
endmodule

// File: rtl/drv_cmd_eval.sv
module drv_cmd_eval
   import drv_cmd_pkg::*;
#(
   parameter int CYL_W = 8
)(
   input  logic [4:0]       op,
   input  logic [1:0]       unit,
   input  logic             head,
   input  logic [CYL_W-1:0] target,
   input  logic             rdy,
   input  logic             wp,
   input  logic             ts,
   input  logic [CYL_W-1:0] limit,
   input  logic [CYL_W-1:0] cur_cyl,
   input  logic             cur_t0,
   output logic [7:0]       st0_n,
   output logic [7:0]       st3_n,
   output logic             wr_en,
   output logic [CYL_W-1:0] wr_cyl,
   output logic [CYL_W-1:0] nxt_cyl,
   output logic             id_ok
);
   cc_e  cc;
   logic se, nr, nxt_t0;

   always_comb begin
      cc     = CC_NORMAL;
      se     = 1'b0;
      nr     = 1'b0;
      wr_en  = 1'b0;
      wr_cyl = target;
      id_ok  = 1'b0;
      case (op)
         OP_SEEK: begin
            if (!rdy) begin
               cc = CC_ABORT; nr = 1'b1;
            end else if (target >= limit) begin
               cc = CC_ABORT; se = 1'b1;
            end else begin
               se = 1'b1; wr_en = 1'b1;
            end
         end
         OP_RECAL: begin
            if (!rdy) begin
               cc = CC_ABORT; nr = 1'b1;
            end else begin
               se = 1'b1; wr_en = 1'b1; wr_cyl = '0;
            end
         end
         OP_READID: begin
            if (!rdy) begin
               cc = CC_RDYCHG; nr = 1'b1;
            end else begin
               id_ok = 1'b1;
            end
         end
         OP_FORMAT: begin
            if (!rdy) begin
               cc = CC_ABORT; nr = 1'b1;
            end else if (wp) begin
               cc = CC_ABORT;
            end
         end
         OP_SENSE, OP_SPECIFY: cc = CC_NORMAL;
         default: cc = CC_BADCMD;
      endcase
      nxt_cyl = wr_en ? wr_cyl : cur_cyl;
      nxt_t0  = wr_en ? (wr_cyl == '0) : cur_t0;
      st0_n   = pack_st0(cc, se, nr, head, unit);
      st3_n   = {1'b0, wp, rdy, nxt_t0, ts, head, unit};
   end
endmodule

// File: rtl/drv_cmd_status.sv
module drv_cmd_status
   import drv_cmd_pkg::*;
#(
   parameter int NUM_DRV = 4,
   parameter int CYL_W   = 8,
   parameter int SIZE_W  = 3
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cmd_valid,
   input  logic [4:0]               cmd_op,
   input  logic [1:0]               cmd_unit,
   input  logic                     cmd_head,
   input  logic [CYL_W-1:0]         cmd_cyl,
   input  logic [SIZE_W-1:0]        cur_size,
   input  logic [NUM_DRV-1:0]       drv_ready,
   input  logic [NUM_DRV-1:0]       drv_wprot,
   input  logic [NUM_DRV-1:0]       drv_twoside,
   input  logic [NUM_DRV*CYL_W-1:0] drv_maxcyl,
   output logic                     done,
   output logic [7:0]               st0,
   output logic [7:0]               st1,
   output logic [7:0]               st2,
   output logic [7:0]               st3,
   output logic [CYL_W-1:0]         res_cyl,
   output logic [7:0]               res_sector,
   output logic [SIZE_W-1:0]        res_size
);
   if (NUM_DRV < 1 || NUM_DRV > MAX_DRV) begin : g_bad_drv
      $error("NUM_DRV must be 1..4");
   end
   if (CYL_W < 1 || CYL_W > 16) begin : g_bad_cyl
      $error("CYL_W must be 1..16");
   end
   if (SIZE_W < 1 || SIZE_W > 8) begin : g_bad_size
      $error("SIZE_W must be 1..8");
   end

   logic             rdy_a [MAX_DRV];
   logic             wp_a  [MAX_DRV];
   logic             ts_a  [MAX_DRV];
   logic [CYL_W-1:0] max_a [MAX_DRV];

   for (genvar g = 0; g < MAX_DRV; g++) begin : g_flags
      if (g < NUM_DRV) begin : g_real
         assign rdy_a[g] = drv_ready[g];
         assign wp_a[g]  = drv_wprot[g];
         assign ts_a[g]  = drv_twoside[g];
         assign max_a[g] = drv_maxcyl[g*CYL_W +: CYL_W];
      end else begin : g_absent
         assign rdy_a[g] = 1'b0;
         assign wp_a[g]  = 1'b0;
         assign ts_a[g]  = 1'b0;
         assign max_a[g] = '0;
      end
   end

   logic [CYL_W-1:0] cur_cyl, wr_cyl, nxt_cyl;
   logic             cur_t0, wr_en, id_ok;
   logic [7:0]       st0_n, st3_n;

   drv_cyl_bank #(.NUM_DRV(NUM_DRV), .CYL_W(CYL_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en & cmd_valid), .sel(cmd_unit),
      .wr_cyl(wr_cyl), .rd_cyl(cur_cyl), .rd_t0(cur_t0)
   );

   drv_cmd_eval #(.CYL_W(CYL_W)) u_eval (
      .op(cmd_op), .unit(cmd_unit), .head(cmd_head), .target(cmd_cyl),
      .rdy(rdy_a[cmd_unit]), .wp(wp_a[cmd_unit]), .ts(ts_a[cmd_unit]),
      .limit(max_a[cmd_unit]), .cur_cyl(cur_cyl), .cur_t0(cur_t0),
      .st0_n(st0_n), .st3_n(st3_n), .wr_en(wr_en), .wr_cyl(wr_cyl),
      .nxt_cyl(nxt_cyl), .id_ok(id_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done       <= 1'b0;
         st0        <= '0;
         st3        <= '0;
         res_cyl    <= '0;
         res_sector <= '0;
         res_size   <= '0;
      end else begin
         done <= cmd_valid;
         if (cmd_valid) begin
            st0        <= st0_n;
            st3        <= st3_n;
            res_cyl    <= nxt_cyl;
            res_sector <= id_ok ? 8'd1 : 8'd0;
            res_size   <= id_ok ? cur_size : '0;
         end
      end
   end

   assign st1 = 8'h00;
   assign st2 = 8'h00;

   AST_DONE_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> done);                                             // R1
   AST_DONE_ONLY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !done);                                           // R1
   AST_SEL_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> st0[2:0] == {$past(cmd_head), $past(cmd_unit)});   // R2
   AST_NOT_READY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && (cmd_op == OP_SEEK || cmd_op == OP_RECAL) && !rdy_a[cmd_unit]
      |=> st0[7:6] == 2'b01 && st0[3] && res_cyl == $past(cur_cyl));   // R3
   AST_RECAL_HOME: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_op == OP_RECAL && rdy_a[cmd_unit]
      |=> res_cyl == '0 && st3[4] && st0[5]);                          // R4
   AST_BOUND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_op == OP_SEEK && rdy_a[cmd_unit] && cmd_cyl >= max_a[cmd_unit]
      |=> st0[7:6] == 2'b01 && res_cyl == $past(cur_cyl));             // R6
   AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !op_known(cmd_op)
      |=> st0[7:6] == 2'b10 && res_cyl == $past(cur_cyl));             // R10
endmodule

// File: tb/sim_drv_cmd_status.sv
module sim_drv_cmd_status;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [4:0]  cmd_op = '0;
   logic [1:0]  cmd_unit = '0;
   logic        cmd_head = 1'b0;
   logic [7:0]  cmd_cyl = '0;
   logic [2:0]  cur_size = 3'd2;
   logic [3:0]  drv_ready = 4'b0111;
   logic [3:0]  drv_wprot = 4'b0100;
   logic [3:0]  drv_twoside = 4'b0011;
   logic [31:0] drv_maxcyl = {8'd10, 8'd77, 8'd80, 8'd40};
   logic        done;
   logic [7:0]  st0, st1, st2, st3, res_cyl, res_sector;
   logic [2:0]  res_size;

   int checks = 0;
   int fails = 0;

   typedef struct {
      logic [7:0] st0;
      logic [7:0] st3;
      logic [7:0] cyl;
      logic [7:0] sec;
      logic [2:0] size;
      string      tag;
   } exp_t;
   exp_t sb [$];
   logic [7:0] m_cyl [4];

   always #4 clk = ~clk;

   drv_cmd_status u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_unit(cmd_unit), .cmd_head(cmd_head), .cmd_cyl(cmd_cyl),
      .cur_size(cur_size), .drv_ready(drv_ready), .drv_wprot(drv_wprot),
      .drv_twoside(drv_twoside), .drv_maxcyl(drv_maxcyl), .done(done),
      .st0(st0), .st1(st1), .st2(st2), .st3(st3), .res_cyl(res_cyl),
      .res_sector(res_sector), .res_size(res_size)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Driver: presents one command and queues the expected result.
   task automatic issue(input logic [4:0] op, input logic [1:0] u, input logic h,
                        input logic [7:0] c, input string tag);
      exp_t e;
      logic [1:0] cc;
      logic se, nr, rdy, id;
      logic [7:0] lim;
      cc = 2'b00; se = 1'b0; nr = 1'b0; id = 1'b0;
      rdy = drv_ready[u];
      lim = drv_maxcyl[u*8 +: 8];
      if (op == 5'h0F) begin
         if (!rdy) begin cc = 2'b01; nr = 1'b1; end
         else if (c >= lim) begin cc = 2'b01; se = 1'b1; end
         else begin se = 1'b1; m_cyl[u] = c; end
      end else if (op == 5'h07) begin
         if (!rdy) begin cc = 2'b01; nr = 1'b1; end
         else begin se = 1'b1; m_cyl[u] = 8'd0; end
      end else if (op == 5'h0A) begin
         if (!rdy) begin cc = 2'b11; nr = 1'b1; end
         else id = 1'b1;
      end else if (op == 5'h0D) begin
         if (!rdy) begin cc = 2'b01; nr = 1'b1; end
         else if (drv_wprot[u]) cc = 2'b01;
      end else if (op != 5'h04 && op != 5'h03) begin
         cc = 2'b10;
      end
      e.st0  = {cc, se, 1'b0, nr, h, u};
      e.st3  = {1'b0, drv_wprot[u], rdy, (m_cyl[u] == 8'd0), drv_twoside[u], h, u};
      e.cyl  = m_cyl[u];
      e.sec  = id ? 8'd1 : 8'd0;
      e.size = id ? cur_size : 3'd0;
      e.tag  = tag;
      @(negedge clk);
      cmd_op = op; cmd_unit = u; cmd_head = h; cmd_cyl = c; cmd_valid = 1'b1;
      sb.push_back(e);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   // Monitor: compares each result against the head of the scoreboard.
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb.size() == 0) begin
            check("R1 unexpected done", 64'd1, 64'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " st0"}, {56'd0, st0}, {56'd0, e.st0});
            check({e.tag, " st1/st2 R2"}, {48'd0, st1, st2}, 64'd0);
            check({e.tag, " st3"}, {56'd0, st3}, {56'd0, e.st3});
            check({e.tag, " cyl"}, {56'd0, res_cyl}, {56'd0, e.cyl});
            check({e.tag, " id"}, {53'd0, res_sector, res_size}, {53'd0, e.sec, e.size});
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) m_cyl[i] = 8'd0;
      repeat (3) @(negedge clk);
      check("R1 reset done", {63'd0, done}, 64'd0);
      check("R1 reset outputs", {24'd0, st0, st3, res_cyl, res_sector}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int d = 0; d < 4; d++) issue(5'h04, d[1:0], 1'b0, 8'd0, "R1 R7 sense after reset");
      issue(5'h0F, 2'd0, 1'b1, 8'd20, "R5 seek in range");
      issue(5'h0F, 2'd1, 1'b0, 8'd79, "R5 seek last cylinder");
      issue(5'h0F, 2'd1, 1'b0, 8'd80, "R6 seek at count");
      issue(5'h0F, 2'd0, 1'b0, 8'd40, "R6 seek at count drive0");
      issue(5'h0F, 2'd0, 1'b0, 8'd200, "R6 seek far beyond");
      issue(5'h04, 2'd0, 1'b1, 8'd0, "R11 drive0 kept");
      issue(5'h0F, 2'd0, 1'b0, 8'd0, "R5 seek to zero");
      issue(5'h0F, 2'd3, 1'b0, 8'd5, "R3 seek not ready");
      issue(5'h07, 2'd3, 1'b1, 8'd0, "R3 recal not ready");
      issue(5'h0D, 2'd3, 1'b0, 8'd0, "R3 format not ready");
      issue(5'h07, 2'd1, 1'b1, 8'd0, "R4 recal");
      issue(5'h0F, 2'd1, 1'b1, 8'd5, "R5 seek drive1");
      issue(5'h0A, 2'd1, 1'b1, 8'd0, "R8 read id");
      issue(5'h0A, 2'd3, 1'b0, 8'd0, "R8 read id not ready");
      issue(5'h0D, 2'd2, 1'b0, 8'd0, "R9 format protected");
      issue(5'h0D, 2'd0, 1'b1, 8'd0, "R9 format writable");
      issue(5'h03, 2'd2, 1'b0, 8'd0, "R9 specify");
      issue(5'h0F, 2'd2, 1'b0, 8'd76, "R5 seek drive2");
      issue(5'h06, 2'd2, 1'b1, 8'd3, "R10 transfer opcode rejected");
      issue(5'h1F, 2'd1, 1'b0, 8'd9, "R10 unknown opcode");
      issue(5'h04, 2'd2, 1'b0, 8'd0, "R10 R11 drive2 kept");
      issue(5'h04, 2'd1, 1'b0, 8'd0, "R11 drive1 kept");
      drv_ready[3] = 1'b1;
      cur_size = 3'd5;
      issue(5'h0F, 2'd3, 1'b1, 8'd9, "R5 seek drive3 last");
      issue(5'h0F, 2'd3, 1'b1, 8'd10, "R6 seek drive3 at count");
      issue(5'h0A, 2'd3, 1'b0, 8'd0, "R8 read id drive3");
      issue(5'h07, 2'd3, 1'b0, 8'd0, "R4 recal drive3");
      repeat (3) @(negedge clk);
      check("R1 all results seen", sb.size(), 64'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule